// File: doc/BRIEF.md
# CORDIC Excitation Sine Generator

This block synthesises a digital sine wave whose frequency is set at run time. A 32-bit phase accumulator advances by a programmable step once per sample period, and its upper 16 bits form an angle in which 65536 counts make one full turn. Each angle goes into an unrolled, pipelined CORDIC engine that runs in rotation mode. The engine is preceded by a quadrant fold, so the iterations only ever see angles inside ±90°. The engine's result is rounded, saturated and given its sign, which yields a 16-bit two's-complement sample.

A programmable divider sets the sample period. One strobe is produced per period. The step value alone sets the output frequency: f = f_sample · step / 2^32. With a typical clock and divider, this covers mains-frequency and multi-kilohertz excitation with fine trim around each. The output register is split into two taps. One tap feeds the excitation DAC path and the other feeds the demodulator as its reference. Both taps carry identical samples on the same cycle.

When the enable input is low, the taps read zero and the phase accumulator keeps its value. Samples still inside the pipeline are discarded. When the enable input rises again, the waveform continues from the held phase.

Top module: `exc_sine_gen`

## Requirements
- R1: Synchronous reset clears both taps to zero with no strobe and sets the phase to zero, so the first sample after enable has angle 0 and value 0.
- R2: While enabled with a constant `rate_div`, the first phase sample is taken on the first enabled clock edge, and strobes occur exactly every `rate_div`+1 cycles.
- R3: Each strobed sample equals round(32767·sin(2π·A/65536)) within ±2 LSB. Here A is bits [31:16] of the phase at the moment the sample was taken.
- R4: The phase advances by `phase_inc` once per sample and wraps modulo 2^32. The fractional low 16 bits carry into the angle.
- R5: The sign of the output is correct in all four quadrants (angle bits [15:14] = 00, 01, 10, 11).
- R6: At angle 16384 (90°) the output is at least 32766, and at angle 49152 (270°) it is at most −32766. The code −32768 never appears.
- R7: On the cycle after `en` is sampled low, both taps read zero with no strobe, and they stay that way while `en` remains low.
- R8: The phase holds while disabled. The first sample after re-enable uses the held phase, and samples that were in flight at disable still count as consumed.
- R9: The excitation tap and the reference tap carry the same value and the same strobe on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low forces the taps to zero and freezes the phase |
| phase_inc | input | 32 | Phase step added once per sample period |
| rate_div | input | 16 | Sample period minus one, in clock cycles |
| exc_sample | output | 16 | Signed sine sample for the excitation DAC path |
| exc_valid | output | 1 | One-cycle strobe marking a new excitation sample |
| ref_sample | output | 16 | Signed sine sample for the demodulator reference |
| ref_valid | output | 1 | One-cycle strobe marking a new reference sample |

## Verification
The hardest situation to reach from the ports is a disable that lands while several samples are still in the pipeline. The phase then has to resume past those lost samples, and it must not rewind. The stimulus creates this by running a burst at one sample per clock and dropping `en` after an exact number of sample periods. The bench then discards the expected items that never appeared and checks that the first sample of the next burst continues from the full advanced phase. Exact 90° and 270° angles come from a power-of-two step, so the peak bound is tested at the true crest. A negative step and a sub-LSB step exercise backward rotation and carry out of the fractional phase bits.

// File: rtl/exc_sine_pkg.sv
package exc_sine_pkg;

    // Output sample and angle widths
    parameter int OUT_W     = 16;
    parameter int ANGLE_W   = 16;
    // Extra fractional bits inside the rotator
    parameter int GUARD_W   = 4;
    parameter int Z_FRAC_W  = 4;
    parameter int MAX_ITER  = 16;

    localparam int XY_W     = OUT_W + GUARD_W + 2;
    localparam int Z_W      = ANGLE_W + Z_FRAC_W + 2;
    localparam int FS_OUT   = (2 ** (OUT_W - 1)) - 1;
    // 1/K in Q0.16, K being the accumulated CORDIC gain
    localparam longint KINV_Q16 = 39797;

    typedef logic signed [XY_W-1:0]  xy_t;
    typedef logic signed [Z_W-1:0]   z_t;
    typedef logic signed [OUT_W-1:0] sample_t;
    typedef logic [ANGLE_W-1:0]      angle_t;

    typedef struct packed {
        logic vld;   // carries a real sample
        logic neg;   // result needs a sign flip after the fold
        xy_t  x;
        xy_t  y;
        z_t   z;     // residual angle, 2^(ANGLE_W+Z_FRAC_W) per turn
    } rot_state_t;

    // Micro-rotation angle atan(2^-idx), scaled to 2^20 counts per turn
    function automatic int atan_step(input int idx);
        case (idx)
            0:  return 131072;
            1:  return 77376;
            2:  return 40883;
            3:  return 20753;
            4:  return 10417;
            5:  return 5213;
            6:  return 2607;
            7:  return 1304;
            8:  return 652;
            9:  return 326;
            10: return 163;
            11: return 81;
            12: return 41;
            13: return 20;
            14: return 10;
            15: return 5;
            default: return 0;
        endcase
    endfunction

    // Initial x preloaded with full scale divided by the CORDIC gain
    function automatic xy_t x_preload();
        longint fs_g;
        fs_g = longint'(FS_OUT) <<< GUARD_W;
        return xy_t'((fs_g * KINV_Q16) >>> 16);
    endfunction

endpackage

// File: rtl/exc_phase_acc.sv
module exc_phase_acc
    import exc_sine_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int DIV_W   = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [DIV_W-1:0]   rate_div,
    output logic               tick,
    output angle_t             angle,
    output logic [PHASE_W-1:0] phase_q
);

    logic [DIV_W-1:0] div_cnt;

    assign tick  = en && (div_cnt == '0);
    assign angle = phase_q[PHASE_W-1 -: ANGLE_W];

    always_ff @(posedge clk) begin
        if (rst) begin
            div_cnt <= '0;
            phase_q <= '0;
        end else if (!en) begin
            div_cnt <= '0;
        end else begin
            if (div_cnt >= rate_div) begin
                div_cnt <= '0;
            end else begin
                div_cnt <= div_cnt + 1'b1;
            end
            if (tick) begin
                phase_q <= phase_q + phase_inc;
            end
        end
    end

endmodule

// File: rtl/exc_quad_fold.sv
module exc_quad_fold
    import exc_sine_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  angle_t     angle,
    output rot_state_t st_q
);

    localparam angle_t HALF_TURN = {1'b1, {(ANGLE_W-1){1'b0}}};
    localparam xy_t    X0        = x_preload();

    logic   flip;
    angle_t folded;
    z_t     z_init;

    // Quadrants 1 and 2 are moved by half a turn; sin(a+pi) = -sin(a)
    assign flip   = angle[ANGLE_W-1] ^ angle[ANGLE_W-2];
    assign folded = flip ? (angle + HALF_TURN) : angle;
    assign z_init = z_t'($signed(folded)) <<< Z_FRAC_W;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q.vld <= 1'b0;
        end else begin
            st_q.vld <= tick;
        end
        st_q.neg <= flip;
        st_q.x   <= X0;
        st_q.y   <= '0;
        st_q.z   <= z_init;
    end

endmodule

// File: rtl/exc_cordic_stage.sv
module exc_cordic_stage
    import exc_sine_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  rot_state_t st_d,
    output rot_state_t st_q
);

    localparam z_t STEP = z_t'(atan_step(IDX));

    xy_t x_in;
    xy_t y_in;
    z_t  z_in;
    xy_t x_sh;
    xy_t y_sh;
    xy_t x_nx;
    xy_t y_nx;
    z_t  z_nx;

    assign x_in = st_d.x;
    assign y_in = st_d.y;
    assign z_in = st_d.z;
    assign x_sh = x_in >>> IDX;
    assign y_sh = y_in >>> IDX;

    always_comb begin
        if (!z_in[Z_W-1]) begin
            x_nx = x_in - y_sh;
            y_nx = y_in + x_sh;
            z_nx = z_in - STEP;
        end else begin
            x_nx = x_in + y_sh;
            y_nx = y_in - x_sh;
            z_nx = z_in + STEP;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st_q.vld <= 1'b0;
        end else begin
            st_q.vld <= st_d.vld;
        end
        st_q.neg <= st_d.neg;
        st_q.x   <= x_nx;
        st_q.y   <= y_nx;
        st_q.z   <= z_nx;
    end

endmodule

// File: rtl/exc_sample_out.sv
module exc_sample_out
    import exc_sine_pkg::*;
#(
    parameter int N_TAPS = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  rot_state_t st_d,
    output sample_t    tap_sample [N_TAPS],
    output logic       tap_valid  [N_TAPS]
);

    localparam xy_t SAT_HI   = xy_t'(FS_OUT);
    localparam xy_t SAT_LO   = -xy_t'(FS_OUT);
    localparam xy_t HALF_LSB = xy_t'(2 ** (GUARD_W - 1));

    xy_t     y_in;
    xy_t     rounded;
    xy_t     clipped;
    xy_t     signed_v;
    sample_t result;

    assign y_in    = st_d.y;
    assign rounded = (y_in + HALF_LSB) >>> GUARD_W;

    always_comb begin
        if (rounded > SAT_HI) begin
            clipped = SAT_HI;
        end else if (rounded < SAT_LO) begin
            clipped = SAT_LO;
        end else begin
            clipped = rounded;
        end
        signed_v = st_d.neg ? -clipped : clipped;
        result   = signed_v[OUT_W-1:0];
    end

    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        always_ff @(posedge clk) begin
            if (rst || !en) begin
                tap_sample[g] <= '0;
                tap_valid[g]  <= 1'b0;
            end else begin
                tap_valid[g] <= st_d.vld;
                if (st_d.vld) begin
                    tap_sample[g] <= result;
                end
            end
        end
    end

endmodule

// File: rtl/exc_sine_gen.sv
module exc_sine_gen
    import exc_sine_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int DIV_W   = 16,
    parameter int ITER    = MAX_ITER
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic [PHASE_W-1:0] phase_inc,
    input  logic [DIV_W-1:0]   rate_div,
    output logic [OUT_W-1:0]   exc_sample,
    output logic               exc_valid,
    output logic [OUT_W-1:0]   ref_sample,
    output logic               ref_valid
);

    localparam int N_TAPS  = 2;
    localparam int TAP_EXC = 0;
    localparam int TAP_REF = 1;

    logic               tick;
    angle_t             angle;
    logic [PHASE_W-1:0] phase_q;
    rot_state_t         pipe [ITER+1];
    sample_t            tap_sample [N_TAPS];
    logic               tap_valid  [N_TAPS];

    exc_phase_acc #(
        .PHASE_W (PHASE_W),
        .DIV_W   (DIV_W)
    ) u_phase (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .phase_inc (phase_inc),
        .rate_div  (rate_div),
        .tick      (tick),
        .angle     (angle),
        .phase_q   (phase_q)
    );

    exc_quad_fold u_fold (
        .clk   (clk),
        .rst   (rst),
        .en    (en),
        .tick  (tick),
        .angle (angle),
        .st_q  (pipe[0])
    );

    for (genvar i = 0; i < ITER; i++) begin : g_iter
        exc_cordic_stage #(
            .IDX (i)
        ) u_stage (
            .clk  (clk),
            .rst  (rst),
            .en   (en),
            .st_d (pipe[i]),
            .st_q (pipe[i+1])
        );
    end

    exc_sample_out #(
        .N_TAPS (N_TAPS)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .st_d       (pipe[ITER]),
        .tap_sample (tap_sample),
        .tap_valid  (tap_valid)
    );

    assign exc_sample = tap_sample[TAP_EXC];
    assign exc_valid  = tap_valid[TAP_EXC];
    assign ref_sample = tap_sample[TAP_REF];
    assign ref_valid  = tap_valid[TAP_REF];

endmodule

// File: rtl/exc_sine_gen_chk.sv
module exc_sine_gen_chk
    import exc_sine_pkg::*;
#(
    parameter int PHASE_W = 32,
    parameter int DIV_W   = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               en,
    input logic               tick,
    input logic [PHASE_W-1:0] phase_q,
    input logic [PHASE_W-1:0] phase_inc,
    input logic [DIV_W-1:0]   rate_div,
    input logic [OUT_W-1:0]   exc_sample,
    input logic               exc_valid,
    input logic [OUT_W-1:0]   ref_sample,
    input logic               ref_valid
);

    localparam logic [OUT_W-1:0] MIN_CODE = {1'b1, {(OUT_W-1){1'b0}}};

    // R1: reset leaves quiet taps and a zero phase
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (exc_sample == '0 && !exc_valid && phase_q == '0));

    // R2: with a divider of one or more, samples are never taken back to back
    assert_tick_gap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick && rate_div != '0 && $stable(rate_div)) |=> !tick);

    // R4: each sample advances the phase by exactly the step
    assert_phase_step_R4: assert property (@(posedge clk) disable iff (rst)
        tick |=> (phase_q == $past(phase_q + phase_inc)));

    // R8: without a sample the phase does not move
    assert_phase_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(phase_q));

    // R7: disable silences both taps on the next cycle
    assert_disable_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (exc_sample == '0 && !exc_valid && ref_sample == '0 && !ref_valid));

    // R6: the most negative code never appears
    assert_no_min_code_R6: assert property (@(posedge clk) disable iff (rst)
        exc_valid |-> (exc_sample != MIN_CODE));

    // R9: excitation and reference taps match every cycle
    assert_taps_equal_R9: assert property (@(posedge clk) disable iff (rst)
        (exc_sample == ref_sample) && (exc_valid == ref_valid));

endmodule

bind exc_sine_gen exc_sine_gen_chk #(
    .PHASE_W (PHASE_W),
    .DIV_W   (DIV_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .tick       (tick),
    .phase_q    (phase_q),
    .phase_inc  (phase_inc),
    .rate_div   (rate_div),
    .exc_sample (exc_sample),
    .exc_valid  (exc_valid),
    .ref_sample (ref_sample),
    .ref_valid  (ref_valid)
);

// File: tb/exc_sine_gen_tb.sv
module exc_sine_gen_tb;

    localparam int    WATCHDOG = 100000;
    localparam int    TOL      = 2;
    localparam real   TWO_PI   = 6.283185307179586;

    typedef struct {
        int    angle;
        int    expv;
        string req;
    } exp_item_t;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [31:0] phase_inc = '0;
    logic [15:0] rate_div  = '0;
    logic [15:0] exc_sample;
    logic        exc_valid;
    logic [15:0] ref_sample;
    logic        ref_valid;

    int checks   = 0;
    int failures = 0;
    int cyc      = 0;
    int run_id   = 0;
    int cur_d    = 1;
    bit done     = 0;
    logic [31:0] model_phase = '0;
    exp_item_t   exp_q[$];

    always #2 clk = ~clk;  // 250 MHz

    exc_sine_gen u_dut (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .phase_inc  (phase_inc),
        .rate_div   (rate_div),
        .exc_sample (exc_sample),
        .exc_valid  (exc_valid),
        .ref_sample (ref_sample),
        .ref_valid  (ref_valid)
    );

    always @(posedge clk) cyc++;

    function automatic int ideal_sine(input int ang);
        real s;
        s = $sin(TWO_PI * real'(ang) / 65536.0);
        return int'(32767.0 * s);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int expv, input string what);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    // Monitor: pops expected samples as strobes arrive
    int last_cyc = 0;
    int last_run = -1;
    always @(negedge clk) begin
        if (!rst && exc_valid) begin
            int act;
            int diff;
            exp_item_t it;
            act = int'($signed(exc_sample));
            check(exc_sample == ref_sample && ref_valid, "R9", int'($signed(ref_sample)), act, "reference tap");
            if (last_run == run_id) begin
                check((cyc - last_cyc) == cur_d, "R2", cyc - last_cyc, cur_d, "strobe spacing");
            end
            last_run = run_id;
            last_cyc = cyc;
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", act, 0, "unexpected strobe");
            end else begin
                it   = exp_q.pop_front();
                diff = act - it.expv;
                if (diff < 0) diff = -diff;
                check(diff <= TOL, it.req, act, it.expv, $sformatf("sample angle=%0d", it.angle));
                if (it.angle % 16384 != 0 && (it.expv > TOL || it.expv < -TOL)) begin
                    check((act > 0) == (it.expv > 0), "R5", act, it.expv, "quadrant sign");
                end
                if (it.angle == 16384) check(act >= 32766, "R6", act, 32767, "positive crest");
                if (it.angle == 49152) check(act <= -32766, "R6", act, -32767, "negative crest");
                check(act != -32768, "R6", act, -32767, "minimum code");
            end
        end
    end

    // Driver: queues expectations, enables for exactly n sample periods
    task automatic run_burst(input logic [31:0] inc, input int div, input int n, input string tag);
        int dd;
        logic [31:0] prev;
        dd = div + 1;
        phase_inc = inc;
        rate_div  = 16'(div);
        for (int k = 0; k < n; k++) begin
            exp_item_t it;
            it.angle = int'(model_phase[31:16]);
            it.expv  = ideal_sine(it.angle);
            if (k == 0) it.req = tag;
            else if (model_phase < prev) it.req = "R4";
            else it.req = "R3";
            exp_q.push_back(it);
            prev = model_phase;
            model_phase = model_phase + inc;
        end
        cur_d = dd;
        run_id++;
        en = 1'b1;
        repeat ((n - 1) * dd + 1) @(negedge clk);
        en = 1'b0;
        for (int w = 0; w < 30; w++) begin
            @(negedge clk);
            if (w == 0 || w == 29) begin
                check(exc_sample == '0 && !exc_valid && ref_sample == '0 && !ref_valid,
                      "R7", int'($signed(exc_sample)), 0, "disabled taps");
            end
        end
        // samples in flight at disable are lost, their phase stays consumed
        exp_q.delete();
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check(exc_sample == '0 && !exc_valid && ref_sample == '0 && !ref_valid,
              "R1", int'($signed(exc_sample)), 0, "reset taps");
        rst = 1'b0;
        @(negedge clk);
        check(exc_sample == '0 && !exc_valid, "R1", int'($signed(exc_sample)), 0, "idle after reset");

        // quarter-turn multiples land exactly on the crests; wraps modulo 2^32
        run_burst(32'h0400_0000, 0, 100, "R1");
        // odd step, divided rate; first sample continues from held phase
        run_burst(32'h0123_4567, 3, 40, "R8");
        // backward rotation
        run_burst(32'hF000_0000, 24, 10, "R8");
        // sub-LSB step: fractional bits carry into the angle
        run_burst(32'h0000_1800, 2, 40, "R4");
        // odd step after a slow run
        run_burst(32'h2AAA_AAAB, 1, 30, "R8");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule